// File: doc/BRIEF.md
# Dual-Buffer Receive Frame Controller

This block takes received frames as a byte stream, one byte per cycle when `rx_valid` is high, with `rx_last` marking the final byte of each frame. It stores every accepted frame in one of two receive buffers, buffer 0 and buffer 1, and fills them in strict alternation. After the last byte of a frame is stored, the block raises a done flag in that buffer's status word. Software polls the status word, copies the frame out over a word-addressed read port, and then clears the done flag to give the buffer back.

The block decides whether to take a frame when the frame's first byte arrives. If the buffer due next still has its done flag set, the whole frame is discarded and a drop counter advances. The next-buffer pointer does not move on a drop. A frame longer than the buffer's data area is cut at capacity, still completed, and marked with an overflow flag. An enable bit in each status word makes the block issue a one-cycle interrupt pulse when a frame completes in that buffer.

Top module: `rx_pingpong_ctrl`

## Requirements
- R1: After reset, both status words read 0, `irq` is low and `drop_count` is 0.
- R2: Host addresses are 32-bit word indices. Buffer 0 data starts at word 0x400 (byte 0x1000) and buffer 1 data at word 0x600 (byte 0x1800). The status words are at words 0x5FF and 0x7FF (byte offset 0x7FC inside each region). A read returns its data on `host_rdata` in the cycle after `host_rd`. A read of an address outside the two regions returns 0.
- R3: Frame byte k is stored in data word k/4 of its buffer at bits [8*(k%4)+7 : 8*(k%4)] (little-endian). In the last word of a frame, the byte lanes beyond the frame's end read 0.
- R4: Status bit 0 (done) reads 1 starting in the cycle after the final byte of an accepted frame is presented.
- R5: The first accepted frame after reset goes to buffer 0. Each later accepted frame goes to the other buffer from the one before it.
- R6: A host write to a status word with bit 0 = 0 clears done and overflow. A write with bit 0 = 1 leaves done unchanged, so the host can never set done.
- R7: Status bit 3 is the interrupt enable and takes the value written. Writing 0x8 on its own sets the enable and releases the buffer.
- R8: A frame whose first byte arrives while the next buffer's done bit is 1 is discarded in full. Neither buffer's data or status changes, the next-buffer pointer stays, and `drop_count` increases by 1.
- R9: Each buffer holds at most 2044 bytes (511 words, ending at byte offset 0x7FB). Bytes past that limit are discarded. The frame is still completed, and status bit 1 (overflow) is set. A frame of exactly 2044 bytes leaves overflow at 0.
- R10: `irq` is high for exactly one cycle, the cycle after a frame completes, if that buffer's enable bit is 1. No pulse is issued when the enable is 0 or for a dropped frame.
- R11: The keep-or-drop decision is fixed at the first byte. Releasing the next buffer while a dropped frame is still arriving does not rescue that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of the frame (qualified by rx_valid) |
| host_addr | input | ADDR_W | Host word address |
| host_wr | input | 1 | Host write strobe (only status words are writable) |
| host_wdata | input | 32 | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 32 | Read data, valid in the cycle after host_rd |
| irq | output | 1 | Frame-complete interrupt pulse |
| drop_count | output | DROP_W | Count of discarded frames, wraps around |

## Verification
Every result is due exactly one clock edge after its cause: done, overflow, `irq` and `drop_count` change on the edge that takes the final (or first) byte, and `host_rdata` changes on the edge that takes `host_rd`. The bench drives every input on the falling edge and samples every output on the next falling edge, half a cycle after the edge that produced it. The `irq` pulse is sampled at that point and again one cycle later to confirm it lasts a single cycle. Data words are compared with a byte pattern computed in the bench from the frame seed, the frame length and the 2044-byte limit.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;

  localparam int NBUF       = 2;
  localparam int ST_DONE    = 0;
  localparam int ST_OVF     = 1;
  localparam int ST_IE      = 3;

  typedef struct packed {
    logic done;
    logic ovf;
    logic ie;
  } buf_stat_t;

  function automatic logic [31:0] stat_word(buf_stat_t s);
    logic [31:0] w;
    w          = '0;
    w[ST_DONE] = s.done;
    w[ST_OVF]  = s.ovf;
    w[ST_IE]   = s.ie;
    return w;
  endfunction

endpackage

// File: rtl/rxpp_ingest.sv
module rxpp_ingest #(
  parameter int BUF_WORDS = 512
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rx_valid_i,
  input  logic [7:0]                   rx_data_i,
  input  logic                         rx_last_i,
  input  logic [rxpp_pkg::NBUF-1:0]    done_vec_i,
  output logic                         wr_en_o,
  output logic                         wr_bank_o,
  output logic [$clog2(BUF_WORDS)-1:0] wr_idx_o,
  output logic [31:0]                  wr_word_o,
  output logic                         fin_o,
  output logic                         fin_bank_o,
  output logic                         fin_ovf_o,
  output logic                         drop_o
);

  localparam int IDX_W     = $clog2(BUF_WORDS);
  localparam int CAP_WORDS = BUF_WORDS - 1;
  localparam int CAP_BYTES = CAP_WORDS * 4;
  localparam int CNT_W     = $clog2(CAP_BYTES + 1);

  logic             in_frame_q, in_frame_n;
  logic             skip_q, skip_n;
  logic             cur_bank_q, cur_bank_n;
  logic             next_bank_q, next_bank_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [31:0]      acc_q, acc_n;
  logic             ovf_q, ovf_n;

  logic             sof, skip_now, bank_now, room, store, ovf_eff;
  logic [CNT_W-1:0] cnt_now;
  logic [1:0]       lane;
  logic [31:0]      acc_base, acc_new;

  always_comb begin
    sof      = rx_valid_i & ~in_frame_q;
    skip_now = sof ? done_vec_i[next_bank_q] : skip_q;
    bank_now = sof ? next_bank_q : cur_bank_q;
    cnt_now  = sof ? '0 : cnt_q;
    ovf_eff  = sof ? 1'b0 : ovf_q;
    room     = (cnt_now < CNT_W'(CAP_BYTES));
    lane     = cnt_now[1:0];
    acc_base = (lane == 2'd0) ? 32'd0 : acc_q;
    acc_new  = acc_base;
    for (int l = 0; l < 4; l++) begin
      if (lane == 2'(l)) acc_new[8*l +: 8] = rx_data_i;
    end
    store     = rx_valid_i & ~skip_now & room;
    wr_en_o   = store & ((lane == 2'd3) | rx_last_i);
    wr_bank_o = bank_now;
    wr_idx_o  = IDX_W'(cnt_now >> 2);
    wr_word_o = acc_new;
    fin_o      = rx_valid_i & rx_last_i & ~skip_now;
    fin_bank_o = bank_now;
    fin_ovf_o  = ovf_eff | ~room;
    drop_o     = sof & skip_now;
  end

  always_comb begin
    in_frame_n  = in_frame_q;
    skip_n      = skip_q;
    cur_bank_n  = cur_bank_q;
    next_bank_n = next_bank_q;
    cnt_n       = cnt_q;
    acc_n       = acc_q;
    ovf_n       = ovf_q;
    if (rx_valid_i) begin
      in_frame_n = ~rx_last_i;
      skip_n     = skip_now;
      cur_bank_n = bank_now;
      cnt_n      = room ? cnt_now + 1'b1 : cnt_now;
      ovf_n      = ovf_eff | (~skip_now & ~room);
      if (store) acc_n = acc_new;
      if (fin_o) next_bank_n = ~bank_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q  <= 1'b0;
      skip_q      <= 1'b0;
      cur_bank_q  <= 1'b0;
      next_bank_q <= 1'b0;
      cnt_q       <= '0;
      acc_q       <= '0;
      ovf_q       <= 1'b0;
    end else if (rx_valid_i) begin
      in_frame_q  <= in_frame_n;
      skip_q      <= skip_n;
      cur_bank_q  <= cur_bank_n;
      next_bank_q <= next_bank_n;
      cnt_q       <= cnt_n;
      acc_q       <= acc_n;
      ovf_q       <= ovf_n;
    end
  end

  // Checking aid: bank of the last completed frame
  logic seen_fin_q, last_fin_bank_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_fin_q      <= 1'b0;
      last_fin_bank_q <= 1'b0;
    end else if (fin_o) begin
      seen_fin_q      <= 1'b1;
      last_fin_bank_q <= fin_bank_o;
    end
  end

  // R9: never write past the data area
  assert_store_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (wr_idx_o < IDX_W'(CAP_WORDS)));

  // R5: consecutive completions alternate between buffers
  assert_alternate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_o && seen_fin_q) |-> (fin_bank_o != last_fin_bank_q));

  // R5: first completion after reset lands in buffer 0
  assert_first_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_o && !seen_fin_q) |-> (fin_bank_o == 1'b0));

endmodule

// File: rtl/rxpp_store.sv
module rxpp_store #(
  parameter int BUF_WORDS = 512
) (
  input  logic                         clk,
  input  logic                         we_i,
  input  logic                         bank_i,
  input  logic [$clog2(BUF_WORDS)-1:0] idx_i,
  input  logic [31:0]                  word_i,
  input  logic                         rd_bank_i,
  input  logic [$clog2(BUF_WORDS)-1:0] rd_idx_i,
  output logic [31:0]                  rd_word_o
);

  localparam int IDX_W     = $clog2(BUF_WORDS);
  localparam int CAP_WORDS = BUF_WORDS - 1;

  logic [31:0] bank_rd [rxpp_pkg::NBUF];

  for (genvar b = 0; b < rxpp_pkg::NBUF; b++) begin : g_bank
    logic [31:0] mem [0:CAP_WORDS-1];
    logic        wen;

    assign wen = we_i & (bank_i == 1'(b)) & (idx_i < IDX_W'(CAP_WORDS));

    always_ff @(posedge clk) begin
      if (wen) mem[idx_i] <= word_i;
    end

    assign bank_rd[b] = (rd_idx_i < IDX_W'(CAP_WORDS)) ? mem[rd_idx_i] : 32'd0;
  end

  assign rd_word_o = bank_rd[rd_bank_i];

endmodule

// File: rtl/rxpp_status.sv
module rxpp_status #(
  parameter int DROP_W = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 fin_i,
  input  logic                                 fin_bank_i,
  input  logic                                 fin_ovf_i,
  input  logic                                 drop_i,
  input  logic [rxpp_pkg::NBUF-1:0]            host_wr_i,
  input  logic [31:0]                          host_wdata_i,
  output logic [rxpp_pkg::NBUF-1:0][31:0]      status_o,
  output logic [rxpp_pkg::NBUF-1:0]            done_o,
  output logic                                 irq_o,
  output logic [DROP_W-1:0]                    drop_cnt_o
);

  import rxpp_pkg::*;

  logic [NBUF-1:0] irq_req;
  logic            wr_clear;
  logic            unused_wdata;

  assign wr_clear     = ~host_wdata_i[ST_DONE];
  assign unused_wdata = ^{host_wdata_i[31:4], host_wdata_i[2:1]};

  for (genvar b = 0; b < NBUF; b++) begin : g_stat
    buf_stat_t st_q, st_n;
    logic      set, hw, en;

    assign set = fin_i & (fin_bank_i == 1'(b));
    assign hw  = host_wr_i[b];
    assign en  = set | hw;

    always_comb begin
      st_n = st_q;
      if (hw) begin
        st_n.ie = host_wdata_i[ST_IE];
        if (wr_clear) begin
          st_n.done = 1'b0;
          st_n.ovf  = 1'b0;
        end
      end
      if (set) begin
        st_n.done = 1'b1;
        st_n.ovf  = fin_ovf_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else if (en) st_q <= st_n;
    end

    assign irq_req[b]  = set & st_q.ie;
    assign status_o[b] = stat_word(st_q);
    assign done_o[b]   = st_q.done;
  end

  logic              irq_q, irq_n;
  logic [DROP_W-1:0] drop_q, drop_n;

  always_comb begin
    irq_n  = |irq_req;
    drop_n = drop_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      drop_q <= '0;
    end else begin
      irq_q <= irq_n;
      if (drop_i) drop_q <= drop_n;
    end
  end

  assign irq_o      = irq_q;
  assign drop_cnt_o = drop_q;

  // R8: a completion only targets a buffer the host has released
  assert_fill_free_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fin_i |-> !done_o[fin_bank_i]);

  // R4: a completion leaves done set on the next cycle
  assert_done_after_fin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fin_i |=> done_o[$past(fin_bank_i)]);

  // R8: a drop only happens while some buffer is still owned by the host
  assert_drop_needs_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drop_i |-> (done_o != '0));

  // R10: no pulse follows a cycle without a completion
  assert_irq_after_fin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_i |=> !irq_o);

endmodule

// File: rtl/rx_pingpong_ctrl.sv
module rx_pingpong_ctrl #(
  parameter int BUF_WORDS    = 512,
  parameter int ADDR_W       = 11,
  parameter int RX_BASE_WORD = 'h400,
  parameter int DROP_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [31:0]       host_wdata,
  input  logic              host_rd,
  output logic [31:0]       host_rdata,
  output logic              irq,
  output logic [DROP_W-1:0] drop_count
);

  import rxpp_pkg::*;

  localparam int IDX_W  = $clog2(BUF_WORDS);
  localparam int SEL_SH = IDX_W + 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // host address decode
  logic             hit, hbank, is_stat;
  logic [IDX_W-1:0] hidx;
  logic [NBUF-1:0]  stat_wr;

  assign hit     = (host_addr >> SEL_SH) == ADDR_W'(RX_BASE_WORD >> SEL_SH);
  assign hbank   = host_addr[IDX_W];
  assign hidx    = host_addr[IDX_W-1:0];
  assign is_stat = (hidx == IDX_W'(BUF_WORDS - 1));

  for (genvar b = 0; b < NBUF; b++) begin : g_swr
    assign stat_wr[b] = host_wr & hit & is_stat & (hbank == 1'(b));
  end

  // ingest -> store / status
  logic             wr_en, wr_bank, fin, fin_bank, fin_ovf, drop;
  logic [IDX_W-1:0] wr_idx;
  logic [31:0]      wr_word, mem_rd;
  logic [NBUF-1:0]  done_vec;
  logic [NBUF-1:0][31:0] status;

  rxpp_ingest #(.BUF_WORDS(BUF_WORDS)) u_ingest (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rx_valid_i (rx_valid),
    .rx_data_i  (rx_data),
    .rx_last_i  (rx_last),
    .done_vec_i (done_vec),
    .wr_en_o    (wr_en),
    .wr_bank_o  (wr_bank),
    .wr_idx_o   (wr_idx),
    .wr_word_o  (wr_word),
    .fin_o      (fin),
    .fin_bank_o (fin_bank),
    .fin_ovf_o  (fin_ovf),
    .drop_o     (drop)
  );

  rxpp_store #(.BUF_WORDS(BUF_WORDS)) u_store (
    .clk       (clk),
    .we_i      (wr_en),
    .bank_i    (wr_bank),
    .idx_i     (wr_idx),
    .word_i    (wr_word),
    .rd_bank_i (hbank),
    .rd_idx_i  (hidx),
    .rd_word_o (mem_rd)
  );

  rxpp_status #(.DROP_W(DROP_W)) u_status (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .fin_i        (fin),
    .fin_bank_i   (fin_bank),
    .fin_ovf_i    (fin_ovf),
    .drop_i       (drop),
    .host_wr_i    (stat_wr),
    .host_wdata_i (host_wdata),
    .status_o     (status),
    .done_o       (done_vec),
    .irq_o        (irq),
    .drop_cnt_o   (drop_count)
  );

  // registered read path
  logic [31:0] rdata_q, rdata_n;

  always_comb begin
    rdata_n = 32'd0;
    if (hit) rdata_n = is_stat ? status[hbank] : mem_rd;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rdata_q <= 32'd0;
    else if (host_rd) rdata_q <= rdata_n;
  end

  assign host_rdata = rdata_q;

  // R2: reads outside both regions return zero one cycle later
  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_rd && !hit) |=> (host_rdata == 32'd0));

  // R2: read data holds while no read is issued
  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !host_rd |=> $stable(host_rdata));

endmodule

// File: tb/test_rx_pingpong_ctrl.sv
module test_rx_pingpong_ctrl;

  localparam logic [10:0] D0 = 11'h400, S0 = 11'h5FF;
  localparam logic [10:0] D1 = 11'h600, S1 = 11'h7FF;
  localparam int CAP = 2044;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0]  rx_data = 8'd0;
  logic [10:0] host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        irq;
  logic [15:0] drop_count;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rx_pingpong_ctrl i_rx_pingpong_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .irq(irq), .drop_count(drop_count)
  );

  function automatic logic [7:0] pat(int seed, int k);
    return 8'((seed * 37 + k + (k >> 8)) & 255);
  endfunction

  function automatic logic [31:0] ew(int seed, int w, int stored);
    logic [31:0] r = '0;
    for (int b = 0; b < 4; b++)
      if (4 * w + b < stored) r[8*b +: 8] = pat(seed, 4 * w + b);
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hwrite(logic [10:0] a, logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(logic [10:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic rd_chk(string tag, logic [10:0] a, logic [31:0] exp);
    logic [31:0] d;
    hread(a, d);
    chk(tag, d, exp);
  endtask

  // clr_at < 0: no host write during the frame
  task automatic send(int len, int seed, int clr_at, logic [10:0] ca,
                      logic [31:0] cd, output logic irq_end, output logic irq_next);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = pat(seed, k); rx_last = (k == len - 1);
      host_wr = (k == clr_at); host_addr = ca; host_wdata = cd;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; host_wr = 1'b0;
    irq_end = irq;
    @(negedge clk);
    irq_next = irq;
  endtask

  task automatic t_reset;
    rd_chk("R1 status0 at reset", S0, 32'h0);
    rd_chk("R1 status1 at reset", S1, 32'h0);
    chk("R1 drop_count at reset", 32'(drop_count), 32'd0);
    chk("R1 irq at reset", 32'(irq), 32'd0);
    rd_chk("R2 unmapped read", 11'h010, 32'h0);
  endtask

  task automatic t_first_frames;
    logic ie, in;
    send(10, 1, -1, '0, '0, ie, in);
    rd_chk("R4 status0 done after frame A", S0, 32'h1);
    rd_chk("R5 status1 untouched by A", S1, 32'h0);
    rd_chk("R3 buf0 word0", D0, ew(1, 0, 10));
    rd_chk("R3 buf0 word1", D0 + 1, ew(1, 1, 10));
    rd_chk("R3 buf0 partial word2", D0 + 2, ew(1, 2, 10));
    chk("R10 no irq with enable clear", 32'(ie), 32'd0);
    send(7, 2, -1, '0, '0, ie, in);
    rd_chk("R5 status1 done after frame B", S1, 32'h1);
    rd_chk("R3 buf1 partial word1", D1 + 1, ew(2, 1, 7));
    rd_chk("R2 unmapped read after frames", 11'h3FF, 32'h0);
  endtask

  task automatic t_drop_full;
    logic ie, in;
    send(5, 3, -1, '0, '0, ie, in);
    chk("R8 drop_count after full drop", 32'(drop_count), 32'd1);
    rd_chk("R8 buf0 data kept", D0, ew(1, 0, 10));
    rd_chk("R8 buf1 data kept", D1, ew(2, 0, 7));
    rd_chk("R8 status0 kept", S0, 32'h1);
    rd_chk("R8 status1 kept", S1, 32'h1);
  endtask

  task automatic t_release;
    logic ie, in;
    hwrite(S0, 32'h0);
    rd_chk("R6 clear done", S0, 32'h0);
    hwrite(S0, 32'h1);
    rd_chk("R6 write one does not set done", S0, 32'h0);
    send(4, 4, -1, '0, '0, ie, in);
    rd_chk("R5 frame D to buf0 (drop kept pointer)", S0, 32'h1);
    rd_chk("R5 frame D data", D0, ew(4, 0, 4));
    rd_chk("R5 status1 still done", S1, 32'h1);
  endtask

  task automatic t_irq;
    logic ie, in;
    hwrite(S1, 32'h8);
    rd_chk("R7 write 0x8 releases and enables", S1, 32'h8);
    hwrite(S0, 32'h8);
    send(6, 5, -1, '0, '0, ie, in);
    chk("R10 irq pulse frame E", 32'(ie), 32'd1);
    chk("R10 irq single cycle frame E", 32'(in), 32'd0);
    rd_chk("R7 status1 done with enable", S1, 32'h9);
    send(3, 6, -1, '0, '0, ie, in);
    chk("R10 irq pulse frame F", 32'(ie), 32'd1);
    rd_chk("R5 frame F to buf0", S0, 32'h9);
    hwrite(S1, 32'h0);
    hwrite(S0, 32'h0);
    send(5, 7, -1, '0, '0, ie, in);
    chk("R10 no irq after enable cleared", 32'(ie), 32'd0);
    rd_chk("R5 frame G to buf1", S1, 32'h1);
    send(8, 8, -1, '0, '0, ie, in);
    rd_chk("R5 frame H to buf0", S0, 32'h1);
    hwrite(S0, 32'h9);
    hwrite(S1, 32'h9);
    rd_chk("R6 write 0x9 keeps done", S0, 32'h9);
    send(5, 9, -1, '0, '0, ie, in);
    chk("R10 no irq for dropped frame", 32'(ie), 32'd0);
    chk("R8 drop_count second drop", 32'(drop_count), 32'd2);
  endtask

  task automatic t_midframe;
    logic ie, in;
    send(6, 10, 2, S1, 32'h8, ie, in);
    chk("R11 drop_count mid-frame release", 32'(drop_count), 32'd3);
    rd_chk("R11 status1 released but empty", S1, 32'h8);
    rd_chk("R11 buf1 data unchanged", D1, ew(7, 0, 5));
    chk("R11 no irq", 32'(ie), 32'd0);
  endtask

  task automatic t_overflow;
    logic ie, in;
    send(2050, 11, -1, '0, '0, ie, in);
    rd_chk("R9 overflow flagged", S1, 32'hB);
    chk("R10 irq on overflow frame", 32'(ie), 32'd1);
    rd_chk("R9 first word", D1, ew(11, 0, CAP));
    rd_chk("R9 last stored word", D1 + 510, ew(11, 510, CAP));
    hwrite(S1, 32'h8);
    rd_chk("R6 clear also clears overflow", S1, 32'h8);
    hwrite(S0, 32'h0);
    send(CAP, 12, -1, '0, '0, ie, in);
    rd_chk("R9 exact capacity no overflow", S0, 32'h1);
    rd_chk("R9 exact capacity last word", D0 + 510, ew(12, 510, CAP));
    chk("R8 drop_count unchanged", 32'(drop_count), 32'd3);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_first_frames();
    t_drop_full();
    t_release();
    t_irq();
    t_midframe();
    t_overflow();
    finished = 1;
    summary();
    $finish;
  end

endmodule